// File: doc/BRIEF.md
# Local Interrupt Priority Controller

This block sits between the interrupt sources of one core and the core itself. It keeps a pending-request bit, an in-service bit and a trigger-mode bit for each of 256 vectors. A vector with a higher number has higher priority. Vectors are grouped into classes of sixteen, and the class is the upper nibble of the vector number.

Software sets a task priority. The block derives a processor priority from the task priority and the class of the highest vector still in service. A pending vector reaches the core only if its class is above the processor priority. When the core acknowledges, the block hands back the winning vector and moves it from pending to in service. If the best request is blocked, the core gets the spurious vector instead. An end-of-interrupt strobe retires the highest in-service vector. If that vector was level triggered, the block sends a broadcast pulse so that the originating source can re-arm, unless the directed-EOI option suppresses it.

A register port holds the task priority and the spurious-vector register, and it can also read back the processor priority.

Top module: `lipc_top`

## Requirements
- R1: After reset, all request, in-service and trigger bits are zero, the task priority reads 0, the spurious-vector register reads 0 and the interrupt output is low.
- R2: Accepting a vector sets its request bit. With the controller enabled and the highest request unblocked, `irq_o` is high. When several requests are pending, the highest-numbered one is served first.
- R3: The processor priority (register select 2) equals the task priority when the task priority's upper nibble is greater than or equal to the upper nibble of the highest in-service vector. Otherwise it equals that vector's upper nibble followed by a zero low nibble. An empty in-service set counts as vector 0.
- R4: A request is blocked when the processor priority is nonzero and the request's upper nibble is at most the processor priority's upper nibble. Acknowledging a blocked request returns bits 7:0 of the spurious-vector register with `ack_spur_o` high, and leaves all arrays unchanged.
- R5: Acknowledging an unblocked request returns its vector, clears its request bit and sets its in-service bit.
- R6: Acknowledging with no request pending, or with the enable bit clear, raises `ack_none_o` and changes nothing.
- R7: An end-of-interrupt clears the highest set in-service bit. With no in-service bit set, it has no effect.
- R8: When an end-of-interrupt retires a level-triggered vector while the directed-EOI bit is clear, `eoi_bcast_o` pulses for one cycle in the next cycle, with that vector on `eoi_bcast_vec_o`.
- R9: No broadcast occurs for an edge-triggered vector or when the directed-EOI bit is set. Re-accepting a vector as edge-triggered clears its trigger bit.
- R10: `irq_o` is high only while the enable bit (bit 8 of the spurious-vector register) is set. A write to the spurious-vector register keeps bits 8:0 and the directed-EOI bit 12, and all other bits read back as zero.
- R11: A task-priority write (register select 0) stores bits 7:0 of the write data, and they read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Accept a vector this cycle |
| acc_vec_i | input | 8 | Vector being accepted |
| acc_level_i | input | 1 | 1 = level triggered, 0 = edge triggered |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | 0 task priority, 1 spurious vector, 2 processor priority (read only), 3 none |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on reg_sel_i) |
| ack_i | input | 1 | Core acknowledge strobe |
| ack_vec_o | output | 8 | Vector returned while ack_i is high |
| ack_none_o | output | 1 | Acknowledge found nothing to deliver |
| ack_spur_o | output | 1 | Acknowledge returned the spurious vector |
| eoi_i | input | 1 | End-of-interrupt strobe |
| irq_o | output | 1 | Interrupt request to the core |
| eoi_bcast_o | output | 1 | One-cycle broadcast pulse for a retired level vector |
| eoi_bcast_vec_o | output | 8 | Vector carried by the broadcast |

## Verification
The bench uses a mix of edge- and level-triggered vectors from the same class and from different classes. Same-class pairs exercise the equality edge of the blocking test, and different-class pairs check that a higher class goes through. It changes the task priority between acknowledges, so the processor priority is set sometimes by the task priority and sometimes by the in-service class, and the readback shows which source won. It also acknowledges and retires with empty arrays, with the controller disabled, and with the directed-EOI option set. It uses the end vectors 0 and 255 and retires a vector that was re-accepted as edge-triggered. These cases separate a correct trigger-bit update and broadcast gate from one that only looks at the first accept.

// File: rtl/lipc_pkg.sv
package lipc_pkg;
   // register select codes on the register port
   typedef enum logic [1:0] {
      SEL_TPR  = 2'd0,
      SEL_SVR  = 2'd1,
      SEL_PPR  = 2'd2,
      SEL_NONE = 2'd3
   } lipc_sel_e;

   // fixed bit positions inside the spurious-vector register
   localparam int SVR_EN_BIT   = 8;
   localparam int SVR_DEOI_BIT = 12;
endpackage

// File: rtl/lipc_msb_find.sv
// Highest-set-bit finder; TWO_LEVEL picks a word-then-bit scan.
module lipc_msb_find #(
   parameter int N         = 256,
   parameter bit TWO_LEVEL = 1'b1,
   parameter int WORD      = 32,
   localparam int IW       = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);
   assign found = |vec;

   generate
      if (!TWO_LEVEL) begin : g_flat
         always_comb begin
            idx = '0;
            for (int i = 0; i < N; i++)
               if (vec[i]) idx = IW'(i);
         end
      end else begin : g_two
         localparam int NW = N / WORD;
         logic [NW-1:0] wany;
         for (genvar w = 0; w < NW; w++) begin : g_w
            assign wany[w] = |vec[w*WORD +: WORD];
         end
         always_comb begin
            int ws;
            int bs;
            ws = 0;
            for (int w = 0; w < NW; w++)
               if (wany[w]) ws = w;
            bs = 0;
            for (int b = 0; b < WORD; b++)
               if (vec[ws*WORD + b]) bs = b;
            idx = IW'(ws*WORD + bs);
         end
      end
   endgenerate
endmodule

// File: rtl/lipc_ppr_calc.sv
// Processor priority and blocking decision, per class of 2**(VEC_W-CLS_W) vectors.
module lipc_ppr_calc #(
   parameter int VEC_W = 8,
   parameter int CLS_W = 4
) (
   input  logic [VEC_W-1:0] tpr,
   input  logic             isr_found,
   input  logic [VEC_W-1:0] isr_top,
   input  logic [VEC_W-1:0] irr_top,
   output logic [VEC_W-1:0] ppr,
   output logic             blocked
);
   localparam int SUB_W = VEC_W - CLS_W;

   logic [CLS_W-1:0] isr_cls;
   assign isr_cls = isr_found ? isr_top[VEC_W-1 -: CLS_W] : '0;

   always_comb begin
      if (tpr[VEC_W-1 -: CLS_W] >= isr_cls) ppr = tpr;
      else                                  ppr = {isr_cls, {SUB_W{1'b0}}};
   end

   assign blocked = (ppr != '0) &&
                    (irr_top[VEC_W-1 -: CLS_W] <= ppr[VEC_W-1 -: CLS_W]);
endmodule

// File: rtl/lipc_top.sv
module lipc_top import lipc_pkg::*; #(
   parameter int NUM_VEC   = 256,
   parameter int CLS_W     = 4,
   parameter int DATA_W    = 32,
   parameter int SCAN_WORD = 32,
   parameter bit TWO_LEVEL = 1'b1,
   localparam int VEC_W    = $clog2(NUM_VEC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid_i,
   input  logic [VEC_W-1:0]  acc_vec_i,
   input  logic              acc_level_i,
   input  logic              reg_wr_i,
   input  logic [1:0]        reg_sel_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   input  logic              ack_i,
   output logic [VEC_W-1:0]  ack_vec_o,
   output logic              ack_none_o,
   output logic              ack_spur_o,
   input  logic              eoi_i,
   output logic              irq_o,
   output logic              eoi_bcast_o,
   output logic [VEC_W-1:0]  eoi_bcast_vec_o
);
   generate
      if ((1 << VEC_W) != NUM_VEC) begin : g_chk_pow2
         $error("NUM_VEC must be a power of two");
      end
      if (CLS_W < 1 || CLS_W >= VEC_W) begin : g_chk_cls
         $error("CLS_W must be between 1 and VEC_W-1");
      end
      if (DATA_W <= SVR_DEOI_BIT || DATA_W < VEC_W) begin : g_chk_data
         $error("DATA_W too narrow for the register fields");
      end
      if (TWO_LEVEL && (NUM_VEC % SCAN_WORD != 0 || NUM_VEC / SCAN_WORD < 2)) begin : g_chk_word
         $error("SCAN_WORD must split NUM_VEC into two or more words");
      end
   endgenerate

   logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
   logic [VEC_W-1:0]   tpr_q, svr_vec_q;
   logic               svr_en_q, svr_deoi_q;

   logic               irr_found, isr_found, blocked;
   logic [VEC_W-1:0]   irr_top, isr_top, ppr;

   lipc_msb_find #(.N(NUM_VEC), .TWO_LEVEL(TWO_LEVEL), .WORD(SCAN_WORD)) i_irr_find (
      .vec(irr_q), .found(irr_found), .idx(irr_top));
   lipc_msb_find #(.N(NUM_VEC), .TWO_LEVEL(TWO_LEVEL), .WORD(SCAN_WORD)) i_isr_find (
      .vec(isr_q), .found(isr_found), .idx(isr_top));
   lipc_ppr_calc #(.VEC_W(VEC_W), .CLS_W(CLS_W)) i_ppr (
      .tpr(tpr_q), .isr_found(isr_found), .isr_top(isr_top),
      .irr_top(irr_top), .ppr(ppr), .blocked(blocked));

   assign irq_o = svr_en_q && irr_found && !blocked;

   // acknowledge response, combinational while ack_i is high
   logic grant;
   always_comb begin
      grant      = 1'b0;
      ack_none_o = 1'b0;
      ack_spur_o = 1'b0;
      ack_vec_o  = '0;
      if (ack_i) begin
         if (!svr_en_q || !irr_found) begin
            ack_none_o = 1'b1;
         end else if (blocked) begin
            ack_spur_o = 1'b1;
            ack_vec_o  = svr_vec_q;
         end else begin
            grant     = 1'b1;
            ack_vec_o = irr_top;
         end
      end
   end

   logic retire;
   assign retire = eoi_i && isr_found;

   logic [NUM_VEC-1:0] irr_d, isr_d, tmr_d;
   always_comb begin
      irr_d = irr_q;
      isr_d = isr_q;
      tmr_d = tmr_q;
      if (grant)  irr_d[irr_top] = 1'b0;
      if (acc_valid_i) begin
         irr_d[acc_vec_i] = 1'b1;
         tmr_d[acc_vec_i] = acc_level_i;
      end
      if (retire) isr_d[isr_top] = 1'b0;
      if (grant)  isr_d[irr_top] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irr_q           <= '0;
         isr_q           <= '0;
         tmr_q           <= '0;
         tpr_q           <= '0;
         svr_vec_q       <= '0;
         svr_en_q        <= 1'b0;
         svr_deoi_q      <= 1'b0;
         eoi_bcast_o     <= 1'b0;
         eoi_bcast_vec_o <= '0;
      end else begin
         irr_q <= irr_d;
         isr_q <= isr_d;
         tmr_q <= tmr_d;
         if (reg_wr_i && reg_sel_i == SEL_TPR) tpr_q <= reg_wdata_i[VEC_W-1:0];
         if (reg_wr_i && reg_sel_i == SEL_SVR) begin
            svr_vec_q  <= reg_wdata_i[VEC_W-1:0];
            svr_en_q   <= reg_wdata_i[SVR_EN_BIT];
            svr_deoi_q <= reg_wdata_i[SVR_DEOI_BIT];
         end
         eoi_bcast_o     <= retire && tmr_q[isr_top] && !svr_deoi_q;
         eoi_bcast_vec_o <= retire ? isr_top : '0;
      end
   end

   always_comb begin
      reg_rdata_o = '0;
      unique case (reg_sel_i)
         SEL_TPR: reg_rdata_o[VEC_W-1:0] = tpr_q;
         SEL_SVR: begin
            reg_rdata_o[VEC_W-1:0]    = svr_vec_q;
            reg_rdata_o[SVR_EN_BIT]   = svr_en_q;
            reg_rdata_o[SVR_DEOI_BIT] = svr_deoi_q;
         end
         SEL_PPR: reg_rdata_o[VEC_W-1:0] = ppr;
         default: reg_rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/lipc_chk.sv
module lipc_chk #(
   parameter int NUM_VEC = 256
) (
   input logic               clk,
   input logic               rst_n,
   input logic               irq_o,
   input logic               sw_en,
   input logic [NUM_VEC-1:0] irr_q,
   input logic [NUM_VEC-1:0] isr_q,
   input logic               ack_i,
   input logic               ack_none_o,
   input logic               ack_spur_o,
   input logic               acc_valid_i,
   input logic               eoi_i,
   input logic               eoi_bcast_o
);
   a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> sw_en);

   a_r2_irq_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (|irr_q));

   a_r8_bcast_after_eoi: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_bcast_o |-> $past(eoi_i));

   a_r6_ack_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      ack_i |-> !(ack_none_o && ack_spur_o));

   a_r4_spur_keeps_requests: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && ack_spur_o && !acc_valid_i) |=> $stable(irr_q));

   a_r5_grant_fills_isr: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !ack_none_o && !ack_spur_o) |=> (|isr_q));
endmodule

bind lipc_top lipc_chk #(.NUM_VEC(NUM_VEC)) i_lipc_chk (
   .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .sw_en(svr_en_q),
   .irr_q(irr_q), .isr_q(isr_q), .ack_i(ack_i), .ack_none_o(ack_none_o),
   .ack_spur_o(ack_spur_o), .acc_valid_i(acc_valid_i), .eoi_i(eoi_i),
   .eoi_bcast_o(eoi_bcast_o));

// File: tb/test_lipc_top.sv
module test_lipc_top;
   localparam logic [3:0] OP_ACCE = 4'h0, OP_ACCL = 4'h1, OP_ACK = 4'h2, OP_EOI = 4'h3,
                          OP_TPR = 4'h4, OP_SVR = 4'h5, OP_SVRD = 4'h6, OP_SVROFF = 4'h7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid_i = 1'b0, acc_level_i = 1'b0;
   logic [7:0]  acc_vec_i = '0;
   logic        reg_wr_i = 1'b0;
   logic [1:0]  reg_sel_i = 2'd3;
   logic [31:0] reg_wdata_i = '0;
   logic [31:0] reg_rdata_o;
   logic        ack_i = 1'b0, eoi_i = 1'b0;
   logic [7:0]  ack_vec_o, eoi_bcast_vec_o;
   logic        ack_none_o, ack_spur_o, irq_o, eoi_bcast_o;

   always #2.5 clk = ~clk;

   lipc_top i_lipc_top (.*);

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // reference model
   logic [255:0] m_irr = '0, m_isr = '0, m_tmr = '0;
   logic [7:0]   m_tpr = '0, m_svec = '0;
   bit           m_en = 1'b0, m_deoi = 1'b0;

   function automatic int top_of(input logic [255:0] a);
      for (int i = 255; i >= 0; i--) if (a[i]) return i;
      return -1;
   endfunction

   function automatic logic [7:0] m_ppr();
      int iv;
      logic [7:0] ivb;
      iv  = top_of(m_isr);
      ivb = (iv < 0) ? 8'd0 : 8'(iv);
      return (m_tpr[7:4] >= ivb[7:4]) ? m_tpr : {ivb[7:4], 4'h0};
   endfunction

   function automatic bit m_blocked();
      logic [7:0] p, r;
      int t;
      t = top_of(m_irr);
      p = m_ppr();
      r = (t < 0) ? 8'd0 : 8'(t);
      return (p != 8'd0) && (r[7:4] <= p[7:4]);
   endfunction

   function automatic bit m_irq();
      return m_en && (m_irr != '0) && !m_blocked();
   endfunction

   task automatic do_op(input logic [3:0] op, input logic [7:0] d);
      bit exp_b;
      logic [7:0] exp_bv;
      int t;
      exp_b = 1'b0;
      exp_bv = '0;
      @(negedge clk);
      acc_valid_i = (op == OP_ACCE || op == OP_ACCL);
      acc_level_i = (op == OP_ACCL);
      acc_vec_i   = d;
      ack_i       = (op == OP_ACK);
      eoi_i       = (op == OP_EOI);
      reg_wr_i    = (op >= OP_TPR);
      reg_sel_i   = (op == OP_TPR) ? 2'd0 : 2'd1;
      reg_wdata_i = (op == OP_TPR) ? {24'hABCDEF, d}
                  : {19'h7FFFF, (op == OP_SVRD), 3'b111, (op != OP_SVROFF), d};
      #1;
      if (op == OP_ACK) begin
         t = top_of(m_irr);
         if (!m_en || t < 0) begin
            chk(ack_none_o && !ack_spur_o, "R6 ack none", {ack_none_o, ack_spur_o}, 2'b10);
         end else if (m_blocked()) begin
            chk(ack_spur_o && !ack_none_o && ack_vec_o == m_svec, "R4 ack spurious",
                {ack_spur_o, ack_vec_o}, {1'b1, m_svec});
         end else begin
            chk(!ack_spur_o && !ack_none_o && ack_vec_o == 8'(t), "R5 ack vector",
                {ack_none_o, ack_spur_o, ack_vec_o}, {2'b00, 8'(t)});
            m_irr[t] = 1'b0;
            m_isr[t] = 1'b1;
         end
      end
      @(posedge clk);
      case (op)
         OP_ACCE, OP_ACCL: begin m_irr[d] = 1'b1; m_tmr[d] = (op == OP_ACCL); end
         OP_EOI: begin
            t = top_of(m_isr);
            if (t >= 0) begin
               exp_b  = m_tmr[t] && !m_deoi;
               exp_bv = 8'(t);
               m_isr[t] = 1'b0;
            end
         end
         OP_TPR:    m_tpr = d;
         OP_SVR:    begin m_svec = d; m_en = 1'b1; m_deoi = 1'b0; end
         OP_SVRD:   begin m_svec = d; m_en = 1'b1; m_deoi = 1'b1; end
         OP_SVROFF: begin m_svec = d; m_en = 1'b0; m_deoi = 1'b0; end
         default: ;
      endcase
      @(negedge clk);
      acc_valid_i = 1'b0; ack_i = 1'b0; eoi_i = 1'b0; reg_wr_i = 1'b0;
      reg_sel_i = 2'd2;
      #1;
      if (exp_b)
         chk(eoi_bcast_o && eoi_bcast_vec_o == exp_bv, "R8 broadcast",
             {eoi_bcast_o, eoi_bcast_vec_o}, {1'b1, exp_bv});
      else
         chk(!eoi_bcast_o, "R9 no broadcast", eoi_bcast_o, 0);
      chk(irq_o == m_irq(), m_en ? "R2 irq" : "R10 irq disabled", irq_o, m_irq());
      chk(reg_rdata_o == {24'h0, m_ppr()}, (op == OP_EOI) ? "R7 ppr after eoi" : "R3 ppr",
          reg_rdata_o, {24'h0, m_ppr()});
   endtask

   localparam int NSTIM = 40;
   localparam logic [11:0] STIM [NSTIM] = '{
      12'h5FF, 12'h031, 12'h152, 12'h200, 12'h200, 12'h420, 12'h300, 12'h200,
      12'h035, 12'h200, 12'h300, 12'h200, 12'h6EE, 12'h190, 12'h200, 12'h300,
      12'h300, 12'h300, 12'h200, 12'h400, 12'h010, 12'h01F, 12'h200, 12'h200,
      12'h300, 12'h200, 12'h300, 12'h700, 12'h040, 12'h200, 12'h5AB, 12'h200,
      12'h300, 12'h1FF, 12'h000, 12'h200, 12'h200, 12'h300, 12'h200, 12'h300
   };

   task automatic rd(input logic [1:0] sel, output logic [31:0] v);
      @(negedge clk);
      reg_sel_i = sel;
      #1;
      v = reg_rdata_o;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(2'd0, v); chk(v == 0, "R1 tpr reset", v, 0);
      rd(2'd1, v); chk(v == 0, "R1 svr reset", v, 0);
      rd(2'd2, v); chk(v == 0, "R1 ppr reset", v, 0);
      chk(!irq_o && !eoi_bcast_o, "R1 outputs idle", {irq_o, eoi_bcast_o}, 0);

      for (int i = 0; i < NSTIM; i++) do_op(STIM[i][11:8], STIM[i][7:0]);

      // R10 register masking
      @(negedge clk);
      reg_wr_i = 1'b1; reg_sel_i = 2'd1; reg_wdata_i = 32'hFFFF_FFFF;
      @(negedge clk);
      reg_wr_i = 1'b0;
      m_svec = 8'hFF; m_en = 1'b1; m_deoi = 1'b1;
      rd(2'd1, v); chk(v == 32'h0000_11FF, "R10 svr mask", v, 32'h0000_11FF);

      // R11 task priority readback
      do_op(OP_TPR, 8'hCD);
      rd(2'd0, v); chk(v == 32'h0000_00CD, "R11 tpr readback", v, 32'hCD);
      do_op(OP_TPR, 8'h00);
      do_op(OP_SVR, 8'h0F);

      // R9 level then edge re-accept: trigger bit must clear
      do_op(OP_ACCL, 8'h60);
      do_op(OP_ACCE, 8'h60);
      do_op(OP_ACK, 8'h00);
      do_op(OP_EOI, 8'h00);
      chk(!eoi_bcast_o, "R9 re-accepted edge", eoi_bcast_o, 0);

      // R7 EOI with empty in-service set
      do_op(OP_EOI, 8'h00);
      chk(m_isr == '0 && reg_rdata_o == 0, "R7 empty eoi", reg_rdata_o, 0);

      finish_run();
   end
endmodule